// File: doc/BRIEF.md
# Clock Output Control-Pin Sequencer

This block sits between two external control pins and the output drivers of a dual-output clock generator. Four configuration bits give each pin a role. The reference pin can select the reference output's frequency, enable that output, or power down the whole device. The main pin can enable the main output or power down the device. The block turns the pins and bits into three things: a tri-state enable for each output driver, a select for the reference clock multiplexer, and a device power-down flag.

Each output enable is released only while that output clock is low, so no pin is cut off mid-pulse. A power-down request first drains both outputs and only then raises the power-down flag. After reset, and after every power-down is released, both outputs stay disabled for a stabilisation count. During that time the oscillator settles.

A configuration lock flag tells the register block to refuse writes whenever the device is not in normal running state. Both control pins pass through two-flop synchronizers before they are decoded. Shutting down the oscillator itself is left to the block that consumes `pwr_down_o`.

Top module: `clkout_ctl`

## Requirements
- R1: With `pdn0_i`=1, `ctl0_i` high requests device power-down regardless of `en0_i`, and `ref_sel_o` equals `sel0_i`. Encoding: `ref_sel_o`=1 selects the prescaled clock and 0 selects the master clock.
- R2: With `en0_i`=1 and `pdn0_i`=0, `ctl0_i` high disables the reference output and low enables it, and `ref_sel_o` equals `sel0_i`.
- R3: With `en0_i`=0, `pdn0_i`=0 and `sel0_i`=1, `ref_sel_o` follows `ctl0_i` (0 master, 1 prescaled) and the reference output stays enabled.
- R4: With `en0_i`, `sel0_i` and `pdn0_i` all 0, `ctl0_i` high requests power-down, and `ctl0_i` low keeps the device running with the reference output disabled.
- R5: With `pdn1_i`=0, `ctl1_i` high disables only the main output. With `pdn1_i`=1, `ctl1_i` high requests power-down.
- R6: The device powers down when either pin's power-down request, as enabled by R1, R4 and R5, is active.
- R7: An enabled output enable falls only on a clock edge at which that output's low flag is 1. While the flag stays 0, the enable holds.
- R8: `pwr_down_o` rises only after both output enables are 0. While powered down, both enables stay 0.
- R9: After reset, and after a power-down request is removed, both output enables stay 0 for `STAB_CYCLES` clock cycles. Only after that may they rise.
- R10: `cfg_lock_o` is 1 while draining, while powered down and during stabilisation, and 0 in normal running.
- R11: With the default bit settings (`en0_i`=1, `sel0_i`=1, `pdn0_i`=0, `pdn1_i`=0), both pins act as output enables and the reference output carries the prescaled clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctl0_i | input | 1 | Reference control pin, asynchronous |
| ctl1_i | input | 1 | Main control pin, asynchronous |
| en0_i | input | 1 | Config: reference pin acts as output enable |
| sel0_i | input | 1 | Config: reference frequency select / pin mux-select mode |
| pdn0_i | input | 1 | Config: reference pin acts as power-down |
| pdn1_i | input | 1 | Config: main pin acts as power-down |
| ref_low_i | input | 1 | Reference output clock is currently low |
| main_low_i | input | 1 | Main output clock is currently low |
| ref_oe_o | output | 1 | Reference output driver enable (0 = high impedance) |
| main_oe_o | output | 1 | Main output driver enable (0 = high impedance) |
| ref_sel_o | output | 1 | Reference mux select: 1 prescaled, 0 master |
| pwr_down_o | output | 1 | Device power-down flag |
| cfg_lock_o | output | 1 | Configuration writes refused |

## Verification
The bench builds the block with `STAB_CYCLES` set to 20 instead of the default 8000. This brings many full power-down and wake round trips into a short run, and lets the bench check the exact edge of the stabilisation window. It drives the low flags directly, so it can hold an output high for as long as it likes and show that disables and power-down entry wait. Random settings of pins and bits are checked in steady state against a decode model written from the requirements.

// File: rtl/clkout_ctl_pkg.sv
package clkout_ctl_pkg;
  typedef enum logic [1:0] {
    PS_RUN   = 2'd0,
    PS_DRAIN = 2'd1,
    PS_DOWN  = 2'd2,
    PS_WAKE  = 2'd3
  } pwr_state_e;

  typedef struct packed {
    logic pd_req;
    logic ref_want;
    logic main_want;
    logic ref_sel;
  } ctl_dec_t;
endpackage

// File: rtl/clkout_ctl_sync.sv
module clkout_ctl_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/clkout_ctl_decode.sv
module clkout_ctl_decode
  import clkout_ctl_pkg::*;
(
  input  logic     c0_i,
  input  logic     c1_i,
  input  logic     en0_i,
  input  logic     sel0_i,
  input  logic     pdn0_i,
  input  logic     pdn1_i,
  output ctl_dec_t dec_o
);
  logic mode_mux, mode_oe, mode_off;
  logic pd0, pd1;

  always_comb begin
    mode_mux = !pdn0_i && !en0_i && sel0_i;
    mode_oe  = !pdn0_i && en0_i;
    mode_off = !pdn0_i && !en0_i && !sel0_i;  // reference unused, pin is shutdown
    pd0 = c0_i && (pdn0_i || mode_off);
    pd1 = c1_i && pdn1_i;
    dec_o.pd_req    = pd0 || pd1;
    dec_o.ref_want  = !mode_off && !(mode_oe && c0_i);
    dec_o.main_want = !(!pdn1_i && c1_i);
    dec_o.ref_sel   = mode_mux ? c0_i : sel0_i;
  end
endmodule

// File: rtl/clkout_ctl_oe_gate.sv
module clkout_ctl_oe_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic want_i,
  input  logic clk_low_i,
  output logic oe_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        oe_o <= 1'b0;
    else if (!oe_o && want_i)           oe_o <= 1'b1;
    else if (oe_o && !want_i && clk_low_i) oe_o <= 1'b0;
  end
endmodule

// File: rtl/clkout_ctl_pwr_seq.sv
module clkout_ctl_pwr_seq
  import clkout_ctl_pkg::*;
#(
  parameter int STAB_CYCLES = 8000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pd_req_i,
  input  logic outs_off_i,
  output logic run_o,
  output logic down_o,
  output logic lock_o
);
  localparam int CW = $clog2(STAB_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(STAB_CYCLES - 1);

  pwr_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      PS_RUN:   if (pd_req_i) state_d = PS_DRAIN;
      PS_DRAIN: if (outs_off_i) state_d = PS_DOWN;
      PS_DOWN:  if (!pd_req_i) begin
                  state_d = PS_WAKE;
                  cnt_d   = '0;
                end
      PS_WAKE: begin
        if (pd_req_i)              state_d = PS_DRAIN;
        else if (cnt_q == CNT_LAST) state_d = PS_RUN;
        else                        cnt_d = cnt_q + 1'b1;
      end
      default: state_d = PS_WAKE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PS_WAKE;  // reset is a power-up: settle first
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign run_o  = state_q == PS_RUN;
  assign down_o = state_q == PS_DOWN;
  assign lock_o = state_q != PS_RUN;
endmodule

// File: rtl/clkout_ctl.sv
module clkout_ctl
  import clkout_ctl_pkg::*;
#(
  parameter int STAB_CYCLES = 8000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ctl0_i,
  input  logic ctl1_i,
  input  logic en0_i,
  input  logic sel0_i,
  input  logic pdn0_i,
  input  logic pdn1_i,
  input  logic ref_low_i,
  input  logic main_low_i,
  output logic ref_oe_o,
  output logic main_oe_o,
  output logic ref_sel_o,
  output logic pwr_down_o,
  output logic cfg_lock_o
);
  localparam int NOUT = 2;

  logic [1:0] pins_s;
  ctl_dec_t   dec;
  logic       run;
  logic [NOUT-1:0] want, low, oe;

  clkout_ctl_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i({ctl1_i, ctl0_i}), .q_o(pins_s)
  );

  clkout_ctl_decode u_dec (
    .c0_i(pins_s[0]), .c1_i(pins_s[1]),
    .en0_i, .sel0_i, .pdn0_i, .pdn1_i,
    .dec_o(dec)
  );

  clkout_ctl_pwr_seq #(.STAB_CYCLES(STAB_CYCLES)) u_seq (
    .clk_i, .rst_ni,
    .pd_req_i(dec.pd_req),
    .outs_off_i(oe == '0),
    .run_o(run), .down_o(pwr_down_o), .lock_o(cfg_lock_o)
  );

  assign want = {dec.main_want, dec.ref_want} & {NOUT{run}};
  assign low  = {main_low_i, ref_low_i};

  for (genvar i = 0; i < NOUT; i++) begin : g_oe
    clkout_ctl_oe_gate u_gate (
      .clk_i, .rst_ni, .want_i(want[i]), .clk_low_i(low[i]), .oe_o(oe[i])
    );
  end

  assign ref_oe_o  = oe[0];
  assign main_oe_o = oe[1];
  assign ref_sel_o = dec.ref_sel;
endmodule

// File: rtl/clkout_ctl_chk.sv
module clkout_ctl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ref_low_i,
  input logic main_low_i,
  input logic ref_oe_o,
  input logic main_oe_o,
  input logic pwr_down_o,
  input logic cfg_lock_o
);
  a_r7_ref_off_when_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ref_oe_o) |-> $past(ref_low_i));
  a_r7_main_off_when_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(main_oe_o) |-> $past(main_low_i));
  a_r8_down_after_drain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwr_down_o) |-> $past(!ref_oe_o && !main_oe_o));
  a_r8_down_outputs_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_down_o |-> (!ref_oe_o && !main_oe_o));
  a_r9_wake_held_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pwr_down_o) |=> (!ref_oe_o && !main_oe_o));
  a_r10_lock_when_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_down_o |-> cfg_lock_o);
endmodule

bind clkout_ctl clkout_ctl_chk u_chk (
  .clk_i, .rst_ni, .ref_low_i, .main_low_i,
  .ref_oe_o, .main_oe_o, .pwr_down_o, .cfg_lock_o
);

// File: tb/tb_clkout_ctl.sv
module tb_clkout_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int STAB = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl0 = 0, ctl1 = 0, en0 = 1, sel0 = 1, pdn0 = 0, pdn1 = 0;
  logic ref_low = 1, main_low = 1;
  logic ref_oe, main_oe, ref_sel, pwr_down, cfg_lock;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkout_ctl #(.STAB_CYCLES(STAB)) dut (
    .clk_i(clk), .rst_ni(rst_n), .ctl0_i(ctl0), .ctl1_i(ctl1),
    .en0_i(en0), .sel0_i(sel0), .pdn0_i(pdn0), .pdn1_i(pdn1),
    .ref_low_i(ref_low), .main_low_i(main_low),
    .ref_oe_o(ref_oe), .main_oe_o(main_oe), .ref_sel_o(ref_sel),
    .pwr_down_o(pwr_down), .cfg_lock_o(cfg_lock)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // expected steady state: {pd, ref_oe, main_oe, sel}
  function automatic logic [3:0] model(input logic c0, c1, e0, s0, p0, p1);
    logic pd, rw, mw, sl;
    pd = (c0 && (p0 || (!e0 && !s0))) || (c1 && p1);
    rw = !(!p0 && !e0 && !s0) && !(!p0 && e0 && c0);
    mw = !(!p1 && c1);
    sl = (!p0 && !e0 && s0) ? c0 : s0;
    return {pd, rw && !pd, mw && !pd, sl};
  endfunction

  task automatic steady(input string req);
    logic [3:0] e;
    e = model(ctl0, ctl1, en0, sel0, pdn0, pdn1);
    chk({4'd0, pwr_down, ref_oe, main_oe, ref_sel}, {4'd0, e}, req);
    chk({7'd0, cfg_lock}, {7'd0, e[3]}, req);
  endtask

  task automatic apply(input logic c0, c1, e0, s0, p0, p1, input string req);
    ctl0 = c0; ctl1 = c1; en0 = e0; sel0 = s0; pdn0 = p0; pdn1 = p1;
    tick(STAB + 12);
    steady(req);
  endtask

  initial begin
    void'($urandom(32'd7153));
    tick(3);
    chk({5'd0, ref_oe, main_oe, pwr_down}, 8'd0, "R9 reset outputs off");
    chk({7'd0, cfg_lock}, 8'd1, "R10 reset lock");
    @(negedge clk) rst_n = 1'b1;
    tick(STAB - 2);
    chk({6'd0, ref_oe, main_oe}, 8'd0, "R9 held off after reset");
    tick(8);
    chk({6'd0, ref_oe, main_oe}, 8'd3, "R11 default both enabled");
    chk({7'd0, ref_sel}, 8'd1, "R11 default prescaled");
    chk({7'd0, cfg_lock}, 8'd0, "R10 run unlocked");

    apply(1, 0, 1, 1, 0, 0, "R2 pin0 disables ref");
    apply(1, 1, 1, 0, 0, 0, "R5 pin1 disables main only, R2 sel");
    apply(0, 0, 0, 1, 0, 0, "R3 mux master");
    apply(1, 0, 0, 1, 0, 0, "R3 mux prescaled");
    apply(0, 0, 0, 0, 0, 0, "R4 active ref off");
    apply(1, 0, 0, 0, 0, 0, "R4 power-down");
    apply(1, 0, 1, 0, 1, 0, "R1 pdn0 overrides en0");
    apply(0, 0, 1, 0, 1, 0, "R1 sel0 master");
    apply(0, 1, 1, 1, 0, 1, "R5 pin1 power-down");
    apply(1, 1, 1, 1, 1, 1, "R6 both requests");

    // R7: disable waits for low
    apply(0, 0, 1, 1, 0, 0, "R11 restore");
    main_low = 0;
    ctl1 = 1;
    tick(10);
    chk({7'd0, main_oe}, 8'd1, "R7 main held while high");
    main_low = 1;
    tick(2);
    chk({7'd0, main_oe}, 8'd0, "R7 main off once low");
    ctl1 = 0;
    tick(5);

    // R8: power-down waits for drain
    ref_low = 0;
    pdn1 = 1; ctl1 = 1;
    tick(10);
    chk({6'd0, pwr_down, ref_oe}, 8'd1, "R8 down waits ref drain");
    chk({7'd0, cfg_lock}, 8'd1, "R10 lock while draining");
    ref_low = 1;
    tick(3);
    chk({5'd0, pwr_down, ref_oe, main_oe}, 8'd4, "R8 down after drain");

    // R9: exact wake window (sync 2 + state 1 + STAB)
    ctl1 = 0;
    tick(STAB + 2);
    chk({5'd0, pwr_down, ref_oe, main_oe}, 8'd0, "R9 held off in wake");
    chk({7'd0, cfg_lock}, 8'd1, "R10 lock in wake");
    tick(4);
    chk({6'd0, ref_oe, main_oe}, 8'd3, "R9 enabled after wake");

    for (int k = 0; k < 40; k++) begin
      logic [5:0] r;
      r = 6'($urandom);
      apply(r[0], r[1], r[2], r[3], r[4], r[5], "R6 random decode");
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        tick(100000);
        fails++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule